// File: doc/BRIEF.md
# Variable-Length Three-Wire Control Word Receiver

This block takes serial control words from a host over three wires: a data line, a bit clock and an enable strobe. All three arrive without any fixed timing relation to the system clock. They are brought into the system clock domain and reduced to edge events. A small state machine then counts bus clock pulses inside each enable window. A result register is loaded whenever the pulse count reaches a position where that field is complete. There are three result registers: four band-switch bits, a 15-bit divisor for the synthesizer's programmable counter, and a 7-bit test/feature word.

The frame length is not announced in the frame. It follows from the pulse on which the enable strobe falls, so the host may send 18-, 19- or 34-bit words. A short or broken frame still updates every field that arrived complete, and it leaves the other fields alone. Pulses after the 34th are counted up to a ceiling and then discarded. After reset, the registers hold safe defaults: band bits off, divisor 256, feature word zero, which selects the 512 reference ratio.

The control state machine has three states:
- `RX_IDLE`: waits for enable.
- `RX_SHIFT`: counts pulses and shifts bits in.
- `RX_SAT`: pulses are ignored after the 35th.

Its transitions are:
- from any state to `RX_SHIFT` on an enable rise, which also clears the pulse count;
- `RX_SHIFT` to `RX_SAT` on the rising edge of the 35th pulse;
- `RX_SHIFT` or `RX_SAT` to `RX_IDLE` on an enable fall.

Top module: `tw_ctrl_rx`

## Requirements
- R1: After reset, `band_o` is 0, `div_o` is 256 and `feat_o` is 0.
- R2: Bits are sampled on the rising bus clock while enable is high. The first bit is the band MSB. The four band bits load `band_o` on the falling edge of pulse 4, with pulse 1 going to `band_o[3]` and pulse 4 to `band_o[0]`.
- R3: Pulses 5 to 19 carry the divisor, MSB first (pulse 5 to `div_o[14]`). `div_o` loads on the falling edge of pulse 19.
- R4: If enable falls after exactly 18 pulses, `div_o` loads the 14 bits of pulses 5 to 18 into `div_o[13:0]`, and `div_o[14]` is forced to 0.
- R5: Pulses 20 to 26 carry the feature word, with pulse 20 going to `feat_o[6]`. `feat_o` loads on the falling edge of pulse 34. Bits on pulses 27 to 34 are don't-care.
- R6: A frame ending after 5 to 17 pulses updates only `band_o`.
- R7: A frame ending before pulse 4 changes no output.
- R8: A frame ending after 20 to 33 pulses updates `band_o` and `div_o` but not `feat_o`.
- R9: Pulses after the 34th have no effect. The pulse count saturates at 35.
- R10: Bus clock pulses while enable is low change no output.
- R11: Every enable rise restarts the pulse count, so a frame after a truncated one is decoded from pulse 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads the defaults |
| sdat_i | input | 1 | Serial data line, asynchronous |
| sclk_i | input | 1 | Bus bit clock, asynchronous |
| sen_i | input | 1 | Frame enable strobe, asynchronous |
| band_o | output | 4 | Band-switch bits |
| div_o | output | 15 | Programmable counter divisor |
| feat_o | output | 7 | Test/feature word |

## Verification
A bus edge reaches a result register three system clocks after it occurs. Two cycles go to synchronizing the input and one to loading the register from the edge strobe. The enable-fall load of an 18-pulse frame has the same latency. The driver holds each bus level for six system clocks, so every bus event has settled before the next one arrives. It pushes the expected register set only twelve cycles after enable falls, and the monitor compares it then, well after any load can still be in flight.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;
    localparam int BAND_W   = 4;
    localparam int DIV_W    = 15;
    localparam int FEAT_W   = 7;
    localparam int PAD_W    = 8;
    // pulse positions derived from field widths
    localparam int BAND_END  = BAND_W;
    localparam int DIV_END   = BAND_W + DIV_W;
    localparam int SHORT_END = DIV_END - 1;
    localparam int FT_FIRST  = DIV_END + 1;
    localparam int FT_LAST   = DIV_END + FEAT_W;
    localparam int FRAME_END = FT_LAST + PAD_W;
    localparam int CNT_SAT   = FRAME_END + 1;
    localparam int CNT_W     = $clog2(CNT_SAT + 1);

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_SAT   = 2'd2
    } rx_state_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= a_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign s_o = pipe[STAGES-1];
endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
    import tw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat,
    input  logic              ck_lvl,
    input  logic              en_lvl,
    output logic              band_ld,
    output logic              div_ld,
    output logic              div_short_ld,
    output logic              feat_ld,
    output logic [DIV_W-1:0]  sh_q,
    output logic [FEAT_W-1:0] ft_q
);
    localparam logic [CNT_W-1:0] P_BAND  = CNT_W'(BAND_END);
    localparam logic [CNT_W-1:0] P_SHORT = CNT_W'(SHORT_END);
    localparam logic [CNT_W-1:0] P_DIV   = CNT_W'(DIV_END);
    localparam logic [CNT_W-1:0] P_FT_LO = CNT_W'(FT_FIRST - 1);
    localparam logic [CNT_W-1:0] P_FT_HI = CNT_W'(FT_LAST);
    localparam logic [CNT_W-1:0] P_FRAME = CNT_W'(FRAME_END);
    localparam logic [CNT_W-1:0] P_SAT   = CNT_W'(CNT_SAT);

    rx_state_t        st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic             ck_d, en_d;
    logic             ck_rise, ck_fall, en_rise, en_fall;

    assign ck_rise = ck_lvl & ~ck_d;
    assign ck_fall = ~ck_lvl & ck_d;
    assign en_rise = en_lvl & ~en_d;
    assign en_fall = ~en_lvl & en_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (en_rise) begin
            st_nx = RX_SHIFT;
        end else begin
            unique case (st)
                RX_IDLE:  st_nx = RX_IDLE;
                RX_SHIFT: begin
                    if (en_fall)                           st_nx = RX_IDLE;
                    else if (ck_rise && cnt == P_SAT - 1'b1) st_nx = RX_SAT;
                end
                RX_SAT:   if (en_fall) st_nx = RX_IDLE;
                default:  st_nx = RX_IDLE;
            endcase
        end
    end

    // edge history, pulse counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_d <= 1'b0;
            en_d <= 1'b0;
            cnt  <= '0;
            sh_q <= '0;
            ft_q <= '0;
        end else begin
            ck_d <= ck_lvl;
            en_d <= en_lvl;
            if (en_rise) begin
                cnt <= '0;
            end else if (st == RX_SHIFT && ck_rise) begin
                cnt <= cnt + 1'b1;
                if (cnt < P_DIV)
                    sh_q <= {sh_q[DIV_W-2:0], dat};
                if (cnt >= P_FT_LO && cnt < P_FT_HI)
                    ft_q <= {ft_q[FEAT_W-2:0], dat};
            end
        end
    end

    // commit strobes
    always_comb begin
        band_ld      = 1'b0;
        div_ld       = 1'b0;
        div_short_ld = 1'b0;
        feat_ld      = 1'b0;
        unique case (st)
            RX_SHIFT: begin
                band_ld      = ck_fall && cnt == P_BAND;
                div_ld       = ck_fall && cnt == P_DIV;
                feat_ld      = ck_fall && cnt == P_FRAME;
                div_short_ld = en_fall && cnt == P_SHORT;
            end
            RX_IDLE, RX_SAT: ;
            default: ;
        endcase
    end

    // R9
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= P_SAT);
    // R9
    sat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == RX_SAT |-> !(band_ld || div_ld || div_short_ld || feat_ld));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && !en_rise) |=> ($stable(cnt) && $stable(sh_q) && $stable(ft_q)));
endmodule

// File: rtl/tw_ctrl_regs.sv
module tw_ctrl_regs
    import tw_rx_pkg::*;
#(
    parameter int RST_DIV = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              band_ld,
    input  logic              div_ld,
    input  logic              div_short_ld,
    input  logic              feat_ld,
    input  logic [DIV_W-1:0]  sh_q,
    input  logic [FEAT_W-1:0] ft_q,
    output logic [BAND_W-1:0] band_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [FEAT_W-1:0] feat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= '0;
            div_q  <= DIV_W'(RST_DIV);
            feat_q <= '0;
        end else begin
            if (band_ld)      band_q <= sh_q[BAND_W-1:0];
            if (div_ld)       div_q  <= sh_q;
            if (div_short_ld) div_q  <= {1'b0, sh_q[DIV_W-2:0]};
            if (feat_ld)      feat_q <= ft_q;
        end
    end
endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
    import tw_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_DIV     = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat_i,
    input  logic              sclk_i,
    input  logic              sen_i,
    output logic [BAND_W-1:0] band_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [FEAT_W-1:0] feat_o
);
    logic [2:0]        bus_s;
    logic              band_ld, div_ld, div_short_ld, feat_ld;
    logic [DIV_W-1:0]  sh_q;
    logic [FEAT_W-1:0] ft_q;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   ({sen_i, sclk_i, sdat_i}),
        .s_o   (bus_s)
    );

    tw_frame_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .dat          (bus_s[0]),
        .ck_lvl       (bus_s[1]),
        .en_lvl       (bus_s[2]),
        .band_ld      (band_ld),
        .div_ld       (div_ld),
        .div_short_ld (div_short_ld),
        .feat_ld      (feat_ld),
        .sh_q         (sh_q),
        .ft_q         (ft_q)
    );

    tw_ctrl_regs #(.RST_DIV(RST_DIV)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .band_ld      (band_ld),
        .div_ld       (div_ld),
        .div_short_ld (div_short_ld),
        .feat_ld      (feat_ld),
        .sh_q         (sh_q),
        .ft_q         (ft_q),
        .band_q       (band_o),
        .div_q        (div_o),
        .feat_q       (feat_o)
    );

    // R2
    band_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_o != $past(band_o) |-> $past(band_ld));
    // R3
    div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_o != $past(div_o) |-> $past(div_ld || div_short_ld));
    // R4
    short_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(div_short_ld) |-> div_o[DIV_W-1] == 1'b0);
    // R5
    feat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feat_o != $past(feat_o) |-> $past(feat_ld));
endmodule

// File: tb/sim_tw_ctrl_rx.sv
module sim_tw_ctrl_rx;
    localparam int HALF   = 6;
    localparam int SETTLE = 12;

    typedef struct {
        logic [3:0]  band;
        logic [14:0] div;
        logic [6:0]  feat;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdat = 1'b0, sclk = 1'b0, sen = 1'b0;
    logic [3:0]  band;
    logic [14:0] div;
    logic [6:0]  feat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sbq[$];

    logic [3:0]  m_band = 4'd0;
    logic [14:0] m_div  = 15'd256;
    logic [6:0]  m_feat = 7'd0;

    always #2 clk = ~clk;

    tw_ctrl_rx u0 (
        .clk(clk), .rst_n(rst_n), .sdat_i(sdat), .sclk_i(sclk), .sen_i(sen),
        .band_o(band), .div_o(div), .feat_o(feat)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected sets and compares with the outputs
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, "band", int'(band), int'(e.band));
            chk(e.tag, "div",  int'(div),  int'(e.div));
            chk(e.tag, "feat", int'(feat), int'(e.feat));
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(string tag);
        exp_t e;
        e.band = m_band; e.div = m_div; e.feat = m_feat; e.tag = tag;
        sbq.push_back(e);
        wait_cyc(2);
    endtask

    // driver: sends n pulses, bit for pulse k is w[64-k], and updates the model
    task automatic frame(int n, logic [63:0] w, string tag);
        sen = 1'b1;
        wait_cyc(HALF);
        for (int k = 1; k <= n; k++) begin
            sdat = w[64-k];
            wait_cyc(HALF);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF);
        sen = 1'b0;
        if (n >= 4)  m_band = w[63:60];
        if (n >= 19) m_div  = w[59:45];
        else if (n == 18) m_div = {1'b0, w[59:46]};
        if (n >= 34) m_feat = w[44:38];
        wait_cyc(SETTLE);
        push(tag);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        push("R1");
        // R2 R3: 19-bit frame
        frame(19, {4'b1010, 15'h5A3C, 45'h0}, "R2_R3");
        // R4: 18-bit frame, B0=1 sits where N14 would be
        frame(18, {4'b0101, 14'h2ABC, 46'h0}, "R4");
        // R5: 34-bit frame with random tail
        frame(34, {4'b0011, 15'h1234, 7'b1011001, 8'hA5, 30'h0}, "R5");
        // R6: enable falls after pulse 9
        frame(9, {4'b1110, 15'h7FFF, 45'h0}, "R6");
        // R7: enable falls after pulse 3
        frame(3, {4'b0001, 60'h0}, "R7");
        // R8: enable falls after pulse 25
        frame(25, {4'b1001, 15'h0F0F, 7'b1111111, 38'h0}, "R8");
        // R9: 40 pulses, tail of ones beyond pulse 34
        frame(40, {4'b1100, 15'h7FFE, 7'b0010110, 8'hFF, 6'b111111, 24'h0}, "R9");
        // R10: pulses with enable low
        for (int k = 0; k < 10; k++) begin
            sdat = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        sdat = 1'b0;
        wait_cyc(SETTLE);
        push("R10");
        // R11: truncated frame then a full one realigned from pulse 1
        frame(10, {4'b0110, 60'hFFFFFFFFFFFFFFF}, "R11");
        frame(19, {4'b0011, 15'h0421, 45'h0}, "R11");
        wait_cyc(10);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule